// File: doc/BRIEF.md
# Nx56 Stuff-Bit Adapter for Bundled Timeslots

The adapter sits between a framed line interface and a payload packer on a bundled data connection that occupies one to eight timeslots of a channelized frame. A line carrying 64 kbps per timeslot delivers one byte per slot. When the connection runs at 56 kbps per slot, one bit of each byte is a filler that the far-end multiplexer sets to one. In the receive (ingress) direction the adapter drops that filler bit and hands the remaining seven payload bits to the packer. In the transmit (egress) direction it takes seven-bit payload groups and rebuilds whole line bytes, forcing the filler bit to one so that the line keeps its ones density.

The filler bit sits either at the first bit sent (byte bit 7, since bytes go out most significant bit first) or at the last bit sent (byte bit 0). A configuration input chooses which. A bypass input selects clear-channel Nx64 operation, in which all eight bits pass through untouched. A timeslot bitmap names the slots that belong to the bundle. The adapter checks that the bitmap describes a legal bundle and stays idle while it does not. For diagnosis, a saturating counter records ingress bytes whose filler bit arrived as zero, which is the usual sign that the two ends disagree about where the filler sits.

Top module: `nx56_bundle_adapter`

## Requirements
- R1: With cfg_stuff_last=0 and cfg_bypass=0, each ingress byte on a member slot gives ing_valid=1 in the following cycle, with ing_data[6:0]=in_byte[6:0] and ing_data[7]=0.
- R2: With cfg_stuff_last=1 and cfg_bypass=0, the ingress payload is taken from the upper seven bits: ing_data[6:0]=in_byte[7:1] and ing_data[7]=0.
- R3: On egress with cfg_bypass=0, the payload eg_pay_data[6:0] goes out in order, most significant bit first. The filler bit is always one. With cfg_stuff_last=0 the byte is {1,pay[6:0]}; with cfg_stuff_last=1 it is {pay[6:0],1}.
- R4: With cfg_bypass=1, both directions pass all eight bits unchanged: ing_data=in_byte, and eg_byte=eg_pay_data.
- R5: Bytes on timeslots whose bit in cfg_ts_map is 0 are ignored. On ingress they raise no ing_valid. On egress a strobe for such a slot raises no eg_byte_valid and leaves any held payload in place.
- R6: cfg_invalid is 0 only when cfg_ts_map holds 1 to 8 set bits that are either consecutive or evenly spaced two slots apart. While cfg_invalid is 1, no ingress byte is accepted and no egress byte is emitted.
- R7: eg_ready is 1 when the adapter holds no payload. It drops the cycle after a payload is accepted and stays low until the assembled byte has been emitted on a member slot.
- R8: A strobe on a member slot while no payload is held emits the fill byte 8'hFF.
- R9: stuff_err_cnt counts accepted non-bypass ingress bytes whose filler bit (bit 7 when cfg_stuff_last=0, bit 0 when cfg_stuff_last=1) is 0. It saturates at its all-ones value and never decreases.
- R10: After reset, ing_valid=0, eg_byte_valid=0, eg_ready=1 and stuff_err_cnt=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ts_map | input | NUM_TS | Bundle membership, one bit per timeslot |
| cfg_stuff_last | input | 1 | 1: filler at byte bit 0; 0: filler at byte bit 7 |
| cfg_bypass | input | 1 | Nx64 clear-channel mode |
| cfg_invalid | output | 1 | Bitmap does not form a legal bundle |
| in_valid | input | 1 | Ingress line byte present |
| in_ts | input | TS_W | Timeslot of the ingress byte |
| in_byte | input | 8 | Ingress line byte |
| ing_valid | output | 1 | Ingress payload strobe |
| ing_data | output | 8 | Ingress payload (7 bits in [6:0], or 8 in bypass) |
| stuff_err_cnt | output | ERR_W | Saturating count of filler bits seen as zero |
| eg_pay_valid | input | 1 | Egress payload offered |
| eg_pay_data | input | 8 | Egress payload (7 bits in [6:0], or 8 in bypass) |
| eg_ready | output | 1 | Egress payload can be accepted |
| eg_slot_strobe | input | 1 | Line asks for a byte for slot eg_ts |
| eg_ts | input | TS_W | Timeslot requested |
| eg_byte_valid | output | 1 | Egress line byte valid |
| eg_byte | output | 8 | Egress line byte |

## Verification
A wrong extraction or insertion shows up in the first line byte or payload group after the faulty configuration takes effect, because each direction has a single register stage. A stale hold flag in the egress path shows one cycle later, either as eg_ready staying low or as a repeated byte where 8'hFF fill was due. A fault in the membership or validity decode is visible in the same cycle on cfg_invalid, and one cycle later as a missing or extra strobe. Counter faults collect over time, so the bench compares the counter against a saturating model after a random run and after a long run of zero filler bits.

// File: rtl/nx56_pkg.sv
package nx56_pkg;

  localparam int unsigned BYTE_W = 8;

  // Line byte -> payload. bypass keeps all eight bits.
  function automatic logic [7:0] nx56_strip(input logic [7:0] b,
                                            input logic       fill_last,
                                            input logic       bypass);
    logic [7:0] r;
    if (bypass)          r = b;
    else if (fill_last)  r = {1'b0, b[7:1]};
    else                 r = {1'b0, b[6:0]};
    return r;
  endfunction

  // Payload -> line byte with a forced-one filler.
  function automatic logic [7:0] nx56_pad(input logic [7:0] p,
                                          input logic       fill_last,
                                          input logic       bypass);
    logic [7:0] r;
    if (bypass)          r = p;
    else if (fill_last)  r = {p[6:0], 1'b1};
    else                 r = {1'b1, p[6:0]};
    return r;
  endfunction

  function automatic logic filler_of(input logic [7:0] b, input logic fill_last);
    return fill_last ? b[0] : b[7];
  endfunction

endpackage

// File: rtl/nx56_bundle_check.sv
module nx56_bundle_check #(
  parameter int unsigned NUM_TS = 32,
  parameter int unsigned MAX_TS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_TS-1:0] ts_map,
  output logic              bad
);

  always_comb begin
    int  n;
    int  lo;
    int  hi;
    int  span;
    logic found;
    logic odd_hit;
    logic contig;
    logic alt;
    n = 0; lo = 0; hi = 0; found = 1'b0; odd_hit = 1'b0;
    for (int i = 0; i < int'(NUM_TS); i++) begin
      if (ts_map[i]) begin
        if (!found) lo = i;
        found = 1'b1;
        hi = i;
        n  = n + 1;
      end
    end
    for (int i = 0; i < int'(NUM_TS); i++) begin
      if (ts_map[i] && ((i % 2) != (lo % 2))) odd_hit = 1'b1;
    end
    span   = hi - lo;
    contig = (span == n - 1);
    alt    = !odd_hit && (span == 2 * (n - 1));
    bad    = (n == 0) || (n > int'(MAX_TS)) || !(contig || alt);
  end

  assert_too_many_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(ts_map) > MAX_TS) |-> bad);
  assert_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_map == '0) |-> bad);

endmodule

// File: rtl/nx56_destuff.sv
module nx56_destuff
  import nx56_pkg::*;
#(
  parameter int unsigned NUM_TS = 32,
  parameter int unsigned ERR_W  = 16,
  localparam int unsigned TS_W  = $clog2(NUM_TS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_TS-1:0] ts_map,
  input  logic              fill_last,
  input  logic              bypass,
  input  logic              bundle_ok,
  input  logic              in_valid,
  input  logic [TS_W-1:0]   in_ts,
  input  logic [7:0]        in_byte,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic [ERR_W-1:0]  err_cnt
);

  logic             take;
  logic             bad_fill;
  logic             valid_d;
  logic [7:0]       data_d;
  logic [ERR_W-1:0] cnt_d;

  always_comb begin
    take     = bundle_ok && in_valid && ts_map[in_ts];
    bad_fill = take && !bypass && !filler_of(in_byte, fill_last);
    valid_d  = take;
    data_d   = take ? nx56_strip(in_byte, fill_last, bypass) : out_data;
    cnt_d    = (bad_fill && (err_cnt != '1)) ? err_cnt + 1'b1 : err_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      err_cnt   <= '0;
    end else begin
      out_valid <= valid_d;
      out_data  <= data_d;
      err_cnt   <= cnt_d;
    end
  end

  assert_msb_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(bypass)) |-> !out_data[7]);
  assert_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !bundle_ok) |=> !out_valid);
  assert_cnt_mono_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (err_cnt >= $past(err_cnt)));
  assert_cnt_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(err_cnt));

endmodule

// File: rtl/nx56_stuff.sv
module nx56_stuff
  import nx56_pkg::*;
#(
  parameter int unsigned NUM_TS = 32,
  localparam int unsigned TS_W  = $clog2(NUM_TS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_TS-1:0] ts_map,
  input  logic              fill_last,
  input  logic              bypass,
  input  logic              bundle_ok,
  input  logic              pay_valid,
  input  logic [7:0]        pay_data,
  output logic              ready,
  input  logic              slot_strobe,
  input  logic [TS_W-1:0]   slot_ts,
  output logic              byte_valid,
  output logic [7:0]        byte_out
);

  localparam logic [7:0] FILL_BYTE = 8'hFF;

  logic       full_q;
  logic [7:0] hold_q;
  logic       full_d;
  logic [7:0] hold_d;
  logic       load;
  logic       emit;
  logic       bv_d;
  logic [7:0] bo_d;

  assign ready = !full_q;

  always_comb begin
    load   = pay_valid && !full_q;
    emit   = bundle_ok && slot_strobe && ts_map[slot_ts];
    hold_d = load ? nx56_pad(pay_data, fill_last, bypass) : hold_q;
    if (load)      full_d = 1'b1;
    else if (emit) full_d = 1'b0;
    else           full_d = full_q;
    bv_d = emit;
    if (emit) bo_d = full_q ? hold_q : FILL_BYTE;
    else      bo_d = byte_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q     <= 1'b0;
      hold_q     <= '0;
      byte_valid <= 1'b0;
      byte_out   <= '0;
    end else begin
      full_q     <= full_d;
      hold_q     <= hold_d;
      byte_valid <= bv_d;
      byte_out   <= bo_d;
    end
  end

  assert_ready_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_valid && ready) |=> !ready);
  assert_first_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_valid && ready && !bypass && !fill_last) |=> hold_q[7]);
  assert_last_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_valid && ready && !bypass && fill_last) |=> hold_q[0]);
  assert_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && ready) |=> (byte_valid && byte_out == FILL_BYTE));
  assert_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !bundle_ok |=> !byte_valid);

endmodule

// File: rtl/nx56_bundle_adapter.sv
module nx56_bundle_adapter #(
  parameter int unsigned NUM_TS = 32,
  parameter int unsigned MAX_TS = 8,
  parameter int unsigned ERR_W  = 16,
  localparam int unsigned TS_W  = $clog2(NUM_TS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_TS-1:0] cfg_ts_map,
  input  logic              cfg_stuff_last,
  input  logic              cfg_bypass,
  output logic              cfg_invalid,
  input  logic              in_valid,
  input  logic [TS_W-1:0]   in_ts,
  input  logic [7:0]        in_byte,
  output logic              ing_valid,
  output logic [7:0]        ing_data,
  output logic [ERR_W-1:0]  stuff_err_cnt,
  input  logic              eg_pay_valid,
  input  logic [7:0]        eg_pay_data,
  output logic              eg_ready,
  input  logic              eg_slot_strobe,
  input  logic [TS_W-1:0]   eg_ts,
  output logic              eg_byte_valid,
  output logic [7:0]        eg_byte
);

  logic bundle_bad;

  nx56_bundle_check #(.NUM_TS(NUM_TS), .MAX_TS(MAX_TS)) u_check (
    .clk    (clk),
    .rst_n  (rst_n),
    .ts_map (cfg_ts_map),
    .bad    (bundle_bad)
  );

  assign cfg_invalid = bundle_bad;

  nx56_destuff #(.NUM_TS(NUM_TS), .ERR_W(ERR_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .ts_map    (cfg_ts_map),
    .fill_last (cfg_stuff_last),
    .bypass    (cfg_bypass),
    .bundle_ok (!bundle_bad),
    .in_valid  (in_valid),
    .in_ts     (in_ts),
    .in_byte   (in_byte),
    .out_valid (ing_valid),
    .out_data  (ing_data),
    .err_cnt   (stuff_err_cnt)
  );

  nx56_stuff #(.NUM_TS(NUM_TS)) u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .ts_map      (cfg_ts_map),
    .fill_last   (cfg_stuff_last),
    .bypass      (cfg_bypass),
    .bundle_ok   (!bundle_bad),
    .pay_valid   (eg_pay_valid),
    .pay_data    (eg_pay_data),
    .ready       (eg_ready),
    .slot_strobe (eg_slot_strobe),
    .slot_ts     (eg_ts),
    .byte_valid  (eg_byte_valid),
    .byte_out    (eg_byte)
  );

endmodule

// File: tb/nx56_bundle_adapter_test.sv
module nx56_bundle_adapter_test;

  localparam int NTS  = 32;
  localparam int EW   = 4;
  localparam int TW   = 5;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NTS-1:0] cfg_ts_map;
  logic           cfg_stuff_last, cfg_bypass, cfg_invalid;
  logic           in_valid;
  logic [TW-1:0]  in_ts;
  logic [7:0]     in_byte;
  logic           ing_valid;
  logic [7:0]     ing_data;
  logic [EW-1:0]  stuff_err_cnt;
  logic           eg_pay_valid;
  logic [7:0]     eg_pay_data;
  logic           eg_ready;
  logic           eg_slot_strobe;
  logic [TW-1:0]  eg_ts;
  logic           eg_byte_valid;
  logic [7:0]     eg_byte;

  int tests = 0;
  int fails = 0;
  int exp_cnt = 0;

  always #2.5 clk = ~clk;

  nx56_bundle_adapter #(.NUM_TS(NTS), .MAX_TS(8), .ERR_W(EW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_ts_map(cfg_ts_map),
    .cfg_stuff_last(cfg_stuff_last), .cfg_bypass(cfg_bypass),
    .cfg_invalid(cfg_invalid), .in_valid(in_valid), .in_ts(in_ts),
    .in_byte(in_byte), .ing_valid(ing_valid), .ing_data(ing_data),
    .stuff_err_cnt(stuff_err_cnt), .eg_pay_valid(eg_pay_valid),
    .eg_pay_data(eg_pay_data), .eg_ready(eg_ready),
    .eg_slot_strobe(eg_slot_strobe), .eg_ts(eg_ts),
    .eg_byte_valid(eg_byte_valid), .eg_byte(eg_byte)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Legal bundle: 1..8 slots at stride 1 or 2.
  function automatic logic exp_ok(input logic [NTS-1:0] m);
    for (int s = 1; s <= 2; s++)
      for (int n = 1; n <= 8; n++)
        for (int st = 0; st + s * (n - 1) < NTS; st++) begin
          logic [NTS-1:0] c;
          c = '0;
          for (int k = 0; k < n; k++) c[st + s * k] = 1'b1;
          if (c == m) return 1'b1;
        end
    return 1'b0;
  endfunction

  function automatic logic [7:0] exp_rx(input logic [7:0] b, input logic last, input logic byp);
    if (byp) return b;
    return last ? {1'b0, b[7:1]} : {1'b0, b[6:0]};
  endfunction

  function automatic logic [7:0] exp_tx(input logic [7:0] p, input logic last, input logic byp);
    if (byp) return p;
    return last ? {p[6:0], 1'b1} : {1'b1, p[6:0]};
  endfunction

  task automatic rx_byte(input logic [TW-1:0] ts, input logic [7:0] b,
                         output logic v, output logic [7:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_ts = ts; in_byte = b;
    @(posedge clk); #1;
    v = ing_valid; d = ing_data;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic tx_load(input logic [7:0] p);
    @(negedge clk);
    eg_pay_valid = 1'b1; eg_pay_data = p;
    @(posedge clk); #1;
    chk("R7 ready low after accept", {31'd0, eg_ready}, 32'd0);
    @(negedge clk);
    eg_pay_valid = 1'b0;
  endtask

  task automatic tx_slot(input logic [TW-1:0] ts, output logic v, output logic [7:0] b);
    @(negedge clk);
    eg_slot_strobe = 1'b1; eg_ts = ts;
    @(posedge clk); #1;
    v = eg_byte_valid; b = eg_byte;
    @(negedge clk);
    eg_slot_strobe = 1'b0;
  endtask

  function automatic void bump(input logic [7:0] b, input logic last, input logic byp);
    logic f;
    f = last ? b[0] : b[7];
    if (!byp && !f && exp_cnt < 15) exp_cnt++;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic       v;
    logic [7:0] d;
    void'($urandom(32'h5A17));
    rst_n = 1'b0;
    cfg_ts_map = 32'h0000_00F0; cfg_stuff_last = 1'b0; cfg_bypass = 1'b0;
    in_valid = 1'b0; in_ts = '0; in_byte = '0;
    eg_pay_valid = 1'b0; eg_pay_data = '0; eg_slot_strobe = 1'b0; eg_ts = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 ing_valid", {31'd0, ing_valid}, 0);
    chk("R10 eg_byte_valid", {31'd0, eg_byte_valid}, 0);
    chk("R10 eg_ready", {31'd0, eg_ready}, 1);
    chk("R10 counter", {28'd0, stuff_err_cnt}, 0);

    // R6 directed bitmaps
    begin
      logic [NTS-1:0] maps [8];
      logic           good [8];
      maps[0] = 32'h0;        good[0] = 0;
      maps[1] = 32'hF0;       good[1] = 1;
      maps[2] = 32'h0005_5500; good[2] = 1;
      maps[3] = 32'hB;        good[3] = 0;
      maps[4] = 32'h1FF;      good[4] = 0;
      maps[5] = 32'hFF00_0000; good[5] = 1;
      maps[6] = 32'h5555;     good[6] = 1;
      maps[7] = 32'h8000_0000; good[7] = 1;
      for (int i = 0; i < 8; i++) begin
        cfg_ts_map = maps[i];
        #1;
        chk("R6 directed map", {31'd0, cfg_invalid}, {31'd0, !good[i]});
      end
    end
    // R6 random bitmaps
    for (int i = 0; i < 60; i++) begin
      logic [NTS-1:0] m;
      int sel;
      sel = int'($urandom % 3);
      if (sel == 0) m = $urandom;
      else begin
        int st, n, s;
        s = 1 + int'($urandom % 2); n = 1 + int'($urandom % 9); st = int'($urandom % 16);
        m = '0;
        for (int k = 0; k < n; k++) m[st + s * k] = 1'b1;
        if (sel == 2) m[$urandom % 32] ^= 1'b1;
      end
      cfg_ts_map = m;
      #1;
      chk("R6 random map", {31'd0, cfg_invalid}, {31'd0, !exp_ok(m)});
    end

    // Ingress, random slot, byte, mode (R1 R2 R4 R5 R9)
    cfg_ts_map = 32'h0000_00F0;
    for (int i = 0; i < 80; i++) begin
      logic [TW-1:0] ts;
      logic [7:0]    b;
      logic          mem;
      ts = (i % 2 == 0) ? TW'(4 + $urandom % 4) : TW'($urandom);
      b  = 8'($urandom);
      cfg_stuff_last = 1'($urandom);
      cfg_bypass     = (($urandom % 4) == 0);
      mem = (ts >= 4 && ts <= 7);
      rx_byte(ts, b, v, d);
      chk("R5 ingress membership", {31'd0, v}, {31'd0, mem});
      if (mem) begin
        if (cfg_bypass)          chk("R4 ingress bypass", {24'd0, d}, {24'd0, exp_rx(b, cfg_stuff_last, 1'b1)});
        else if (cfg_stuff_last) chk("R2 ingress last", {24'd0, d}, {24'd0, exp_rx(b, 1'b1, 1'b0)});
        else                     chk("R1 ingress first", {24'd0, d}, {24'd0, exp_rx(b, 1'b0, 1'b0)});
        bump(b, cfg_stuff_last, cfg_bypass);
      end
    end
    chk("R9 counter after random", {28'd0, stuff_err_cnt}, exp_cnt);

    // R6: invalid map blocks ingress
    cfg_ts_map = 32'h0000_000B; cfg_bypass = 1'b0;
    rx_byte(5'd0, 8'h00, v, d);
    chk("R6 ingress blocked", {31'd0, v}, 0);
    chk("R9 no count when blocked", {28'd0, stuff_err_cnt}, exp_cnt);

    // R9 saturation
    cfg_ts_map = 32'h0000_00F0; cfg_stuff_last = 1'b0;
    for (int i = 0; i < 20; i++) begin
      rx_byte(5'd5, 8'h12, v, d);
      bump(8'h12, 1'b0, 1'b0);
    end
    chk("R9 saturated", {28'd0, stuff_err_cnt}, 32'd15);
    cfg_bypass = 1'b1;
    rx_byte(5'd5, 8'h00, v, d);
    chk("R4 bypass raw", {24'd0, d}, 32'h00);
    chk("R9 held at max", {28'd0, stuff_err_cnt}, 32'd15);

    // Egress directed
    cfg_bypass = 1'b0; cfg_stuff_last = 1'b0;
    tx_slot(5'd6, v, d);
    chk("R8 fill valid", {31'd0, v}, 1);
    chk("R8 fill byte", {24'd0, d}, 32'hFF);
    tx_load(8'h2A);
    tx_slot(5'd9, v, d);
    chk("R5 egress non-member", {31'd0, v}, 0);
    chk("R7 ready still low", {31'd0, eg_ready}, 0);
    tx_slot(5'd4, v, d);
    chk("R3 egress first", {24'd0, d}, {24'd0, exp_tx(8'h2A, 1'b0, 1'b0)});
    chk("R7 ready back", {31'd0, eg_ready}, 1);
    cfg_stuff_last = 1'b1;
    tx_load(8'h00);
    tx_slot(5'd7, v, d);
    chk("R3 egress last", {24'd0, d}, 32'h01);

    // R6: invalid map blocks egress
    cfg_ts_map = 32'h0000_0003 | 32'h0000_0010;
    tx_slot(5'd0, v, d);
    chk("R6 egress blocked", {31'd0, v}, 0);
    cfg_ts_map = 32'h0000_00F0;

    // Egress random (R3 R4)
    for (int i = 0; i < 40; i++) begin
      logic [7:0] p;
      p = 8'($urandom);
      cfg_stuff_last = 1'($urandom);
      cfg_bypass     = (($urandom % 4) == 0);
      if (!cfg_bypass) p[7] = 1'b0;
      tx_load(p);
      tx_slot(TW'(4 + $urandom % 4), v, d);
      if (cfg_bypass) chk("R4 egress bypass", {24'd0, d}, {24'd0, p});
      else            chk("R3 egress random", {24'd0, d}, {24'd0, exp_tx(p, cfg_stuff_last, 1'b0)});
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule